// File: doc/BRIEF.md
# ADC channel-scan conversion controller

This block is the digital sequencer that sits in front of an analog-to-digital converter core. Software sets it up through a small 16-bit register file. It then starts a scan from one of three sources: a register write, a timer underflow pulse, or a falling edge on an active-low external pin. The scan walks a range of input channels. For each channel the block holds the core's start line for a programmable sample window, waits for the core's done pulse and stores the 10-bit result.

Each stored result sets a completion flag. Reading the data register clears that flag. If a new result lands while the completion flag is still set, the previous result was lost, and a sticky overwrite flag records this. Writing one to the overwrite bit clears it. Each flag drives an interrupt line through its own enable. A scan runs either once over the range or in a continuous loop that software stops by clearing the run bit.

Top module: `adc_scan_ctrl`

Register map (`reg_addr`):
- Address 0, setup word:
  - bits 2:0 hold the sample field `S`.
  - bits 5:4 hold the trigger select `T`.
  - bits 10:8 hold the first channel.
  - bits 14:12 hold the last channel.
  - bit 15 selects loop mode.
- Address 1, control/status word:
  - bit 0: enable.
  - bit 1: run.
  - bit 4: completion interrupt enable.
  - bit 5: overwrite interrupt enable.
  - bit 8: completion flag.
  - bit 9: overwrite flag.
  - bit 10: busy.
  - bits 14:12: current channel.
- Address 2, result: bits 9:0.
- Unused bits, and address 3, read as 0.

## Requirements
- R1: After reset the setup word reads 0x0007, the control/status word reads 0x0000, the result word reads 0x0000, and both interrupt outputs are low.
- R2: With T=0, a write to the control/status word that has bit 0 and bit 1 both set starts a scan when the block is idle; busy (bit 10) and run (bit 1) then read 1.
- R3: With enable set and the block idle, a one-cycle high pulse on `timer_uf` starts a scan when T=1, and a falling edge of `ext_trig_n` starts a scan when T=3. T=2 never starts a scan. A hardware trigger has no effect while enable is 0 or while a scan is already busy.
- R4: For every channel, `adc_start` stays high for exactly S+2 consecutive clock cycles. It then falls and stays low until `adc_done` arrives.
- R5: Channels are converted in ascending order from the first channel to the last channel. If the last channel is below the first channel, only the first channel is converted. `adc_ch` and status bits 14:12 both show the channel being converted.
- R6: On an `adc_done` pulse the block stores `adc_data` into result bits 9:0 and sets the completion flag (bit 8). A read of address 2 clears that flag.
- R7: A result stored while the completion flag is still set sets the overwrite flag (bit 9). The flag holds until a control/status write with bit 9 set clears it.
- R8: In single mode (bit 15 = 0), the clock edge that stores the last channel's result clears both busy and run.
- R9: In loop mode the scan wraps from the last channel back to the first channel. A control/status write with bit 1 clear stops the scan in the next cycle, with busy low and `adc_start` low.
- R10: `irq_done` equals completion flag AND bit 4. `irq_ovr` equals overwrite flag AND bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has a side effect only at address 2) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| timer_uf | input | 1 | Timer underflow pulse |
| ext_trig_n | input | 1 | External trigger, active low, acts on its falling edge |
| adc_start | output | 1 | Start/sample request to the analog core |
| adc_ch | output | 3 | Channel presented to the analog core |
| adc_done | input | 1 | One-cycle completion pulse from the analog core |
| adc_data | input | 10 | Conversion result from the analog core |
| irq_done | output | 1 | Completion interrupt request |
| irq_ovr | output | 1 | Overwrite interrupt request |

## Verification
A wrong sample counter shows up within one channel: the start pulse has the wrong width as soon as the window ends. A wrong channel step shows up as a wrong `adc_ch` at the start of the next window. Flag errors show up at the status word one cycle after the done pulse or the data read that should have moved them. A wrong end-of-scan decision shows up in the cycle after the last done pulse, as busy still high or a spurious extra window.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int RW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        timer_uf,
  input  logic        ext_trig_n,
  output logic        adc_start,
  output logic [2:0]  adc_ch,
  input  logic        adc_done,
  input  logic [RW-1:0] adc_data,
  output logic        irq_done,
  output logic        irq_ovr
);
  localparam logic [1:0] IDLE = 2'd0, SAMP = 2'd1, WAIT = 2'd2;

  logic [1:0]  st;
  logic [2:0]  samp, chs, che, ch;
  logic [1:0]  tsel;
  logic        loop_md, en, cie, oie, cf, ovr, ext_q;
  logic [3:0]  cnt;
  logic [RW-1:0] res;

  logic wr_cfg, wr_ctl, rd_dat, busy, sw_go, hw_go, go, abort, stored, last;

  assign wr_cfg = reg_wr && reg_addr == 2'd0;
  assign wr_ctl = reg_wr && reg_addr == 2'd1;
  assign rd_dat = reg_rd && reg_addr == 2'd2;
  assign busy   = st != IDLE;
  assign sw_go  = wr_ctl && reg_wdata[1] && reg_wdata[0] && tsel == 2'd0;
  assign hw_go  = en && ((tsel == 2'd1 && timer_uf) || (tsel == 2'd3 && ext_q && !ext_trig_n));
  assign go     = !busy && (sw_go || hw_go);
  assign abort  = busy && wr_ctl && !(reg_wdata[1] && reg_wdata[0]);
  assign stored = st == WAIT && adc_done && !abort;
  assign last   = ch >= che;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp <= 3'd7; tsel <= 2'd0; chs <= 3'd0; che <= 3'd0; loop_md <= 1'b0;
      en <= 1'b0; cie <= 1'b0; oie <= 1'b0;
      cf <= 1'b0; ovr <= 1'b0; res <= '0; ext_q <= 1'b1;
    end else begin
      ext_q <= ext_trig_n;
      if (wr_cfg) begin
        samp <= reg_wdata[2:0]; tsel <= reg_wdata[5:4];
        chs <= reg_wdata[10:8]; che <= reg_wdata[14:12]; loop_md <= reg_wdata[15];
      end
      if (wr_ctl) begin
        en <= reg_wdata[0]; cie <= reg_wdata[4]; oie <= reg_wdata[5];
      end
      if (stored) res <= adc_data;
      if (stored) cf <= 1'b1;
      else if (rd_dat) cf <= 1'b0;
      if (stored && cf && !rd_dat) ovr <= 1'b1;
      else if (wr_ctl && reg_wdata[9]) ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ch <= 3'd0; cnt <= 4'd0;
    end else begin
      case (st)
        IDLE: if (go) begin
          st <= SAMP; ch <= chs; cnt <= 4'd0;
        end
        SAMP: if (abort) st <= IDLE;
              else if (cnt == {1'b0, samp} + 4'd1) st <= WAIT;
              else cnt <= cnt + 4'd1;
        WAIT: if (abort) st <= IDLE;
              else if (adc_done) begin
                cnt <= 4'd0;
                if (!last) begin ch <= ch + 3'd1; st <= SAMP; end
                else if (loop_md) begin ch <= chs; st <= SAMP; end
                else st <= IDLE;
              end
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = {loop_md, che, 1'b0, chs, 2'b0, tsel, 1'b0, samp};
      2'd1: reg_rdata = {1'b0, ch, 1'b0, busy, ovr, cf, 2'b0, oie, cie, 2'b0, busy, en};
      2'd2: reg_rdata = {{(16-RW){1'b0}}, res};
      default: reg_rdata = 16'h0000;
    endcase
  end

  assign adc_start = st == SAMP;
  assign adc_ch    = ch;
  assign irq_done  = cf && cie;
  assign irq_ovr   = ovr && oie;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       adc_start,
  input logic       adc_done,
  input logic [1:0] st,
  input logic [1:0] tsel,
  input logic       cf,
  input logic       ovr
);
  logic [3:0] run_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_len <= 4'd0;
    else run_len <= adc_start ? run_len + 4'd1 : 4'd0;

  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> run_len < 4'd9);

  a_r3_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == 2'd2 && st == 2'd0 && !reg_wr) |=> st == 2'd0);

  a_r6_store_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && adc_done && !reg_wr) |=> cf);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && !(st == 2'd2 && adc_done)) |=> !cf);

  a_r7_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && adc_done && !reg_wr && cf && !(reg_rd && reg_addr == 2'd2)) |=> ovr);
endmodule

bind adc_scan_ctrl adc_scan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .adc_start(adc_start), .adc_done(adc_done), .st(st), .tsel(tsel), .cf(cf), .ovr(ovr)
);

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic timer_uf = 0, ext_trig_n = 1;
  logic adc_start, adc_done = 0;
  logic [2:0] adc_ch;
  logic [9:0] adc_data = 0;
  logic irq_done, irq_ovr;

  int total = 0, bad = 0;
  int run = 0, last_run = 0;
  bit finished = 0;
  bit cf_m, ovr_m;
  logic [2:0] ch_m;

  always #10 clk = ~clk;

  adc_scan_ctrl u0 (.*);

  always @(posedge clk)
    if (adc_start) run <= run + 1;
    else if (run != 0) begin last_run <= run; run <= 0; end

  function automatic logic [15:0] stat(logic [2:0] c, bit b, bit o, bit f, bit oi, bit ci, bit e);
    return {1'b0, c, 1'b0, b, o, f, 2'b0, oi, ci, 2'b0, b, e};
  endfunction

  function automatic logic [2:0] end_ch(logic [2:0] s, logic [2:0] e);
    return (e < s) ? s : e;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd_data(string req, logic [15:0] exp);
    reg_addr = 2; reg_rd = 1; #1;
    chk(req, reg_rdata, exp);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic seq(int trig, logic [2:0] samp, logic [2:0] s, logic [2:0] e,
                     bit lp, bit rd_each, bit ci, bit oi);
    logic [15:0] v;
    logic [15:0] ctl;
    logic [2:0] lastc;
    int laps;
    ctl = {10'b0, oi, ci, 4'b0} | 16'h0001;
    wr(0, {lp, e, 1'b0, s, 2'b0, 2'(trig), 1'b0, samp});
    wr(1, ctl | 16'h0200);
    reg_addr = 2; reg_rd = 1; @(negedge clk); reg_rd = 0;
    cf_m = 0; ovr_m = 0;
    peek(1, v);
    chk("R7 clear by write", {15'b0, v[9]}, 16'h0);
    if (trig == 0) wr(1, ctl | 16'h0002);
    else if (trig == 1) begin timer_uf = 1; @(negedge clk); timer_uf = 0; end
    else if (trig == 3) begin ext_trig_n = 0; @(negedge clk); ext_trig_n = 1; end
    else begin
      timer_uf = 1; ext_trig_n = 0; @(negedge clk); timer_uf = 0; ext_trig_n = 1;
      @(negedge clk);
      peek(1, v);
      chk("R3 reserved select", v, stat(ch_m, 0, 0, 0, oi, ci, 1));
      chk("R3 reserved no start", {15'b0, adc_start}, 16'h0);
      return;
    end
    lastc = end_ch(s, e);
    laps = lp ? 2 : 1;
    for (int l = 0; l < laps; l++) begin
      for (int c = s; c <= lastc; c++) begin
        bit fin;
        chk("R5 adc_ch", {13'b0, adc_ch}, 16'(c));
        peek(1, v);
        chk("R5 indicator", {13'b0, v[14:12]}, 16'(c));
        if (trig == 1) begin timer_uf = 1; @(negedge clk); timer_uf = 0; end
        if (trig == 3) begin ext_trig_n = 0; @(negedge clk); ext_trig_n = 1; end
        while (adc_start) @(negedge clk);
        @(negedge clk);
        chk("R4 window length", 16'(last_run), 16'(samp + 2));
        chk("R4 start low while waiting", {15'b0, adc_start}, 16'h0);
        repeat ($urandom_range(2, 0)) @(negedge clk);
        adc_data = 10'($urandom);
        adc_done = 1; @(negedge clk); adc_done = 0;
        if (cf_m) ovr_m = 1;
        cf_m = 1;
        fin = !lp && (c == lastc);
        ch_m = lp && (c == lastc) ? s : (fin ? 3'(c) : 3'(c + 1));
        peek(1, v);
        chk(fin ? "R8 single end" : "R6 R7 status after store", v,
            stat(ch_m, !fin, ovr_m, cf_m, oi, ci, 1));
        chk("R10 irq_done", {15'b0, irq_done}, {15'b0, cf_m & ci});
        chk("R10 irq_ovr", {15'b0, irq_ovr}, {15'b0, ovr_m & oi});
        if (rd_each) begin
          rd_data("R6 result", {6'b0, adc_data});
          cf_m = 0;
          peek(1, v);
          chk("R6 read clears flag", {15'b0, v[8]}, 16'h0);
        end
      end
    end
    if (lp) begin
      wr(1, ctl);
      peek(1, v);
      chk("R9 stop busy", {5'b0, v[10], 9'b0, v[1]}, 16'h0);
      chk("R9 stop start", {15'b0, adc_start}, 16'h0);
    end
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(0, v); chk("R1 setup reset", v, 16'h0007);
    peek(1, v); chk("R1 status reset", v, 16'h0000);
    peek(2, v); chk("R1 result reset", v, 16'h0000);
    chk("R1 irq reset", {14'b0, irq_done, irq_ovr}, 16'h0);
    ch_m = 0;

    wr(0, 16'h0010);
    timer_uf = 1; @(negedge clk); timer_uf = 0; @(negedge clk);
    peek(1, v); chk("R3 disabled timer ignored", v, 16'h0000);

    seq(0, 3'd0, 3'd2, 3'd4, 0, 1, 1, 1);     // R2 shortest window
    seq(0, 3'd7, 3'd5, 3'd1, 0, 1, 1, 0);     // R5 end below start
    seq(1, 3'd3, 3'd0, 3'd7, 0, 0, 1, 1);     // R7 overwrite, R3 timer
    seq(3, 3'd2, 3'd6, 3'd7, 0, 1, 0, 1);     // R3 external edge
    seq(2, 3'd1, 3'd0, 3'd3, 0, 1, 1, 1);     // R3 reserved
    seq(0, 3'd1, 3'd1, 3'd3, 1, 1, 1, 0);     // R9 loop mode
    seq(1, 3'd4, 3'd3, 3'd3, 1, 0, 1, 1);     // R9 loop single channel

    for (int i = 0; i < 30; i++) begin
      int t;
      t = $urandom_range(2, 0);
      if (t == 2) t = 3;
      seq(t, 3'($urandom), 3'($urandom), 3'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(1234);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule